// File: doc/BRIEF.md
# Two-Slot Segment Schedule Controller

This controller runs a frame-processing program of up to `MAX_SEG` segments on two reconfigurable processing slots. Each segment is a library component named by a 6-bit index held in a small schedule buffer, which is written through a load port while the controller is idle. While one slot executes a segment, the controller has the other slot reconfigured with the component for the following segment. The cost of reconfiguration is thus hidden behind execution whenever it is shorter than the segment.

Captured raw frames alternate between two raw banks. The first segment of a frame reads the raw bank that holds it. Intermediate results alternate between two temporal banks, and the last segment writes one of two output banks. When a frame's last segment finishes, the output module is started on that output bank and the schedule wraps to its first entry. As a result, capture of the next frame, processing of the current one and output of the previous one overlap.

A frame that completes capture while another is still being processed is dropped, and a sticky overrun flag records the loss. Slot handshakes are level requests answered by done pulses for reconfiguration, and start pulses answered by done pulses for execution.

Top module: `segsched_top`

## Requirements
- R1: After reset, `cfgReq`, `startSlot`, `outStart`, `overrun`, `slotSel`, `rawWrSel`, `rawRdSel` and `outWrSel` are all 0.
- R2: A `loadEn` cycle writes the 6-bit component index `loadData` into schedule entry `loadAddr`, but only while the controller is idle. Loads issued after the schedule has started are ignored, and the old entry is the one that is requested later.
- R3: In idle, `runEn` with a nonzero `segCount` latches the segment count, clamping it to `MAX_SEG`. One cycle later, `cfgReq` equals 2'b01 and `cfgIdx` carries entry 0. `runEn` with `segCount` = 0 is ignored.
- R4: A reconfiguration request `cfgReq[s]` stays high until `cfgDone[s]` is seen, and drops in the following cycle. At most one request is outstanding at any time.
- R5: A slot gets a one-cycle `startSlot` pulse only when all three hold: its reconfiguration has completed, it is not executing, and a captured frame is held. In the cycle of that pulse, `cfgReq` for the other slot rises with `cfgIdx` set to the next entry, which is entry 0 after the last entry.
- R6: A `slotDone` pulse from the executing slot switches `slotSel` to the other slot in the next cycle. A `slotDone` from the idle slot, or one that arrives when no segment is running, changes nothing.
- R7: Routing follows the current segment number n. `srcRaw` is 1 exactly when n = 0. `dstOut` is 1 exactly when n is the last segment. `tmpWrSel` = n mod 2 and `tmpRdSel` is its inverse, so segment n reads the temporal bank that segment n-1 wrote.
- R8: When the last segment finishes, `outStart` pulses for one cycle with `outBank` equal to the output bank just written. `outWrSel` then toggles, and the segment number returns to 0.
- R9: A `frameCaptured` pulse that arrives when no frame is held makes `rawRdSel` take the bank just filled and toggles `rawWrSel`. The frame is held until its last segment finishes.
- R10: A `frameCaptured` pulse that arrives while a frame is held sets `overrun`, which stays set until reset, and leaves `rawWrSel` and `rawRdSel` unchanged.
- R11: If the next slot has not reported `cfgDone` when the current segment finishes, no start is issued until it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Starts the schedule from idle |
| segCount | input | CW | Number of segments in the schedule |
| loadEn | input | 1 | Schedule entry write strobe |
| loadAddr | input | AW | Schedule entry to write |
| loadData | input | IDX_W | Library component index |
| frameCaptured | input | 1 | Pulse: the acquisition bank is full |
| cfgDone | input | 2 | Per-slot reconfiguration complete pulse |
| slotDone | input | 2 | Per-slot segment execution complete pulse |
| cfgReq | output | 2 | Per-slot reconfiguration request (level) |
| cfgIdx | output | IDX_W | Component index to load into the requested slot |
| startSlot | output | 2 | Per-slot execution start pulse |
| slotSel | output | 1 | Slot connected to the data memory |
| rawWrSel | output | 1 | Raw bank receiving acquisition |
| rawRdSel | output | 1 | Raw bank holding the frame in process |
| tmpRdSel | output | 1 | Temporal bank read by the current segment |
| tmpWrSel | output | 1 | Temporal bank written by the current segment |
| srcRaw | output | 1 | Current segment reads the raw bank |
| dstOut | output | 1 | Current segment writes the output bank |
| outWrSel | output | 1 | Output bank the last segment writes |
| outStart | output | 1 | Pulse: start the output module |
| outBank | output | 1 | Output bank handed to the output module |
| overrun | output | 1 | Sticky: a captured frame was dropped |

## Verification
The assertions assume three things about the inputs. `frameCaptured`, `cfgDone` and `slotDone` are single-cycle pulses. A slot reports `slotDone` only after it was started, and a completion without a matching request or start is ignored by design. The bench models the two slots as responders: each raises `cfgDone` only after a request has been held for a set latency, and raises `slotDone` a fixed number of cycles after each start. Extra `slotDone` pulses are injected only on the slot that is not selected, so the rule that such pulses are ignored is exercised without breaking the input assumptions.

// File: rtl/segsched_pkg.sv
package segsched_pkg;

  // Strobes from the sequencing control to the schedule/bank datapath
  typedef struct packed {
    logic idle;     // controller has not started; schedule may be written
    logic init;     // begin a run: reset segment number, latch count
    logic advance;  // the executing segment reported completion
  } seqStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;

endpackage

// File: rtl/segsched_datapath.sv
module segsched_datapath
  import segsched_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int MAX_SEG = 8,
  parameter int AW      = 3,
  parameter int CW      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       str,
  input  logic             loadEn,
  input  logic [AW-1:0]    loadAddr,
  input  logic [IDX_W-1:0] loadData,
  input  logic [CW-1:0]    segCount,
  input  logic             frameCaptured,
  output logic [IDX_W-1:0] entryFirst,
  output logic [IDX_W-1:0] entryNext,
  output logic             frameHeld,
  output logic             srcRaw,
  output logic             dstOut,
  output logic             tmpRdSel,
  output logic             tmpWrSel,
  output logic             rawWrSel,
  output logic             rawRdSel,
  output logic             outWrSel,
  output logic             outStart,
  output logic             outBank,
  output logic             overrun
);

  localparam logic [CW-1:0] MAXC = CW'(MAX_SEG);

  logic [IDX_W-1:0] sched [MAX_SEG];
  logic [AW-1:0]    segIdx;
  logic [CW-1:0]    numSegR;
  logic [CW-1:0]    segPlus;
  logic             segLast;
  logic [AW-1:0]    nextPos;
  logic             busy;

  assign segPlus    = CW'(segIdx) + CW'(1);
  assign segLast    = (segPlus == numSegR);
  assign nextPos    = segLast ? '0 : segPlus[AW-1:0];
  assign entryFirst = sched[0];
  assign entryNext  = sched[nextPos];
  assign frameHeld  = busy;

  // Bank routing for the current segment
  assign srcRaw   = (segIdx == '0);
  assign dstOut   = segLast;
  assign tmpWrSel = segIdx[0];
  assign tmpRdSel = ~segIdx[0];

  // Schedule buffer: writable only before the run starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_SEG; i++) sched[i] <= '0;
    end else if (str.idle && loadEn && (int'(loadAddr) < MAX_SEG)) begin
      sched[loadAddr] <= loadData;
    end
  end

  // Segment counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segIdx  <= '0;
      numSegR <= CW'(1);
    end else if (str.init) begin
      segIdx  <= '0;
      numSegR <= (segCount > MAXC) ? MAXC : segCount;
    end else if (str.advance) begin
      segIdx  <= segLast ? '0 : segPlus[AW-1:0];
    end
  end

  // Frame ownership and ping-pong banks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      rawWrSel <= 1'b0;
      rawRdSel <= 1'b0;
      outWrSel <= 1'b0;
      outStart <= 1'b0;
      outBank  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      outStart <= 1'b0;
      if (str.advance && segLast) begin
        busy     <= 1'b0;
        outStart <= 1'b1;
        outBank  <= outWrSel;
        outWrSel <= ~outWrSel;
      end
      if (frameCaptured) begin
        if (!busy) begin
          busy     <= 1'b1;
          rawRdSel <= rawWrSel;
          rawWrSel <= ~rawWrSel;
        end else begin
          overrun  <= 1'b1;
        end
      end
    end
  end

  // R10: overrun never clears by itself
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R10: a dropped frame leaves both raw selects where they were
  a_r10_drop_keeps_banks: assert property (@(posedge clk) disable iff (!rstN)
    (frameCaptured && frameHeld) |=> ($stable(rawWrSel) && $stable(rawRdSel)));

  // R9: an accepted frame is held and never shares a bank with acquisition
  a_r9_accept_splits_banks: assert property (@(posedge clk) disable iff (!rstN)
    (frameCaptured && !frameHeld) |=> (frameHeld && (rawRdSel != rawWrSel)));

  // R8: output module gets the bank just finished, not the next one written
  a_r8_out_bank: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> (outBank != outWrSel));

  // R7/R8: after the last segment the schedule is back at the raw-reading entry
  a_r7_wrap_to_raw: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> srcRaw);

endmodule

// File: rtl/segsched_control.sv
module segsched_control
  import segsched_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             countNz,
  input  logic             frameHeld,
  input  logic [IDX_W-1:0] entryFirst,
  input  logic [IDX_W-1:0] entryNext,
  input  logic [1:0]       cfgDone,
  input  logic [1:0]       slotDone,
  output seqStrobe_t       str,
  output logic [1:0]       cfgReq,
  output logic [IDX_W-1:0] cfgIdx,
  output logic [1:0]       startSlot,
  output logic             slotSel
);

  localparam int NSLOT = 2;

  seqState_t        state;
  logic             actSlot;
  logic             running;
  logic [NSLOT-1:0] loaded;
  logic             initNow;
  logic             startNow;
  logic             finishNow;

  assign initNow   = (state == ST_IDLE) && runEn && countNz;
  assign startNow  = (state == ST_RUN) && !running && loaded[actSlot] && frameHeld;
  assign finishNow = (state == ST_RUN) && running && slotDone[actSlot];

  assign str.idle    = (state == ST_IDLE);
  assign str.init    = initNow;
  assign str.advance = finishNow;
  assign slotSel     = actSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      actSlot <= 1'b0;
      running <= 1'b0;
      cfgIdx  <= '0;
    end else if (initNow) begin
      state   <= ST_RUN;
      actSlot <= 1'b0;
      running <= 1'b0;
      cfgIdx  <= entryFirst;
    end else if (startNow) begin
      running <= 1'b1;
      cfgIdx  <= entryNext;
    end else if (finishNow) begin
      running <= 1'b0;
      actSlot <= ~actSlot;
    end
  end

  // Per-slot reconfiguration and start handshakes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReq    <= '0;
      loaded    <= '0;
      startSlot <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        startSlot[s] <= startNow && (actSlot == 1'(s));
        if (initNow) begin
          cfgReq[s] <= (s == 0);
          loaded[s] <= 1'b0;
        end else if (startNow && (actSlot != 1'(s))) begin
          cfgReq[s] <= 1'b1;
          loaded[s] <= 1'b0;
        end else if (cfgReq[s] && cfgDone[s]) begin
          cfgReq[s] <= 1'b0;
          loaded[s] <= 1'b1;
        end
      end
    end
  end

  // R4: never more than one reconfiguration outstanding
  a_r4_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cfgReq));

  // R4: a request without its done stays up
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgReq & ~cfgDone) != 2'b00) |=> (cfgReq != 2'b00));

  // R5: at most one slot started at a time
  a_r5_single_start: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(startSlot));

  // R5/R11: a slot is never started while its reconfiguration is pending
  a_r11_no_start_during_cfg: assert property (@(posedge clk) disable iff (!rstN)
    (startSlot & cfgReq) == 2'b00);

  // R6: completion of the executing slot hands memory to the other slot
  a_r6_mux_switch: assert property (@(posedge clk) disable iff (!rstN)
    (running && slotDone[actSlot]) |=> (slotSel != $past(slotSel)));

endmodule

// File: rtl/segsched_top.sv
module segsched_top
  import segsched_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int MAX_SEG = 8,
  localparam int AW = (MAX_SEG > 1) ? $clog2(MAX_SEG) : 1,
  localparam int CW = $clog2(MAX_SEG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [CW-1:0]    segCount,
  input  logic             loadEn,
  input  logic [AW-1:0]    loadAddr,
  input  logic [IDX_W-1:0] loadData,
  input  logic             frameCaptured,
  input  logic [1:0]       cfgDone,
  input  logic [1:0]       slotDone,
  output logic [1:0]       cfgReq,
  output logic [IDX_W-1:0] cfgIdx,
  output logic [1:0]       startSlot,
  output logic             slotSel,
  output logic             rawWrSel,
  output logic             rawRdSel,
  output logic             tmpRdSel,
  output logic             tmpWrSel,
  output logic             srcRaw,
  output logic             dstOut,
  output logic             outWrSel,
  output logic             outStart,
  output logic             outBank,
  output logic             overrun
);

  seqStrobe_t       str;
  logic [IDX_W-1:0] entryFirst;
  logic [IDX_W-1:0] entryNext;
  logic             frameHeld;

  segsched_control #(.IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .countNz(|segCount),
    .frameHeld(frameHeld), .entryFirst(entryFirst), .entryNext(entryNext),
    .cfgDone(cfgDone), .slotDone(slotDone), .str(str),
    .cfgReq(cfgReq), .cfgIdx(cfgIdx), .startSlot(startSlot), .slotSel(slotSel)
  );

  segsched_datapath #(.IDX_W(IDX_W), .MAX_SEG(MAX_SEG), .AW(AW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .segCount(segCount), .frameCaptured(frameCaptured),
    .entryFirst(entryFirst), .entryNext(entryNext), .frameHeld(frameHeld),
    .srcRaw(srcRaw), .dstOut(dstOut), .tmpRdSel(tmpRdSel), .tmpWrSel(tmpWrSel),
    .rawWrSel(rawWrSel), .rawRdSel(rawRdSel), .outWrSel(outWrSel),
    .outStart(outStart), .outBank(outBank), .overrun(overrun)
  );

endmodule

// File: tb/segsched_top_tb.sv
module segsched_top_tb;

  localparam int NMAX = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic [3:0] segCount = '0;
  logic       loadEn = 1'b0;
  logic [2:0] loadAddr = '0;
  logic [5:0] loadData = '0;
  logic       frameCaptured = 1'b0;
  logic [1:0] cfgDone = '0;
  logic [1:0] slotDone = '0;
  logic [1:0] cfgReq, startSlot;
  logic [5:0] cfgIdx;
  logic slotSel, rawWrSel, rawRdSel, tmpRdSel, tmpWrSel, srcRaw, dstOut;
  logic outWrSel, outStart, outBank, overrun;

  segsched_top u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .segCount(segCount), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadData(loadData), .frameCaptured(frameCaptured),
    .cfgDone(cfgDone), .slotDone(slotDone), .cfgReq(cfgReq), .cfgIdx(cfgIdx),
    .startSlot(startSlot), .slotSel(slotSel), .rawWrSel(rawWrSel),
    .rawRdSel(rawRdSel), .tmpRdSel(tmpRdSel), .tmpWrSel(tmpWrSel),
    .srcRaw(srcRaw), .dstOut(dstOut), .outWrSel(outWrSel), .outStart(outStart),
    .outBank(outBank), .overrun(overrun)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mSched [NMAX];
  bit mIdle, mRun, mBusy, mAct, mRawW, mRawR, mOutW, mOutStart, mOutBank, mOver;
  bit [1:0] mReq, mLoaded, mStart;
  int mSeg, mK, mIdx;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mSched[i]) mSched[i] = 0;
      mIdle = 1; mRun = 0; mBusy = 0; mAct = 0; mRawW = 0; mRawR = 0;
      mOutW = 0; mOutStart = 0; mOutBank = 0; mOver = 0;
      mReq = 0; mLoaded = 0; mStart = 0; mSeg = 0; mK = 1; mIdx = 0;
    end else begin
      bit oIdle, oRun, oBusy, oAct, oRawW, oOutW;
      bit [1:0] oLoaded, oReq;
      int oSeg;
      oIdle = mIdle; oRun = mRun; oBusy = mBusy; oAct = mAct; oRawW = mRawW;
      oOutW = mOutW; oLoaded = mLoaded; oReq = mReq; oSeg = mSeg;
      mStart = 0; mOutStart = 0;
      if (oIdle) begin
        if (runEn && segCount != 0) begin
          mIdle = 0; mSeg = 0; mK = (segCount > NMAX) ? NMAX : int'(segCount);
          mAct = 0; mRun = 0; mLoaded = 0; mReq = 2'b01; mIdx = mSched[0];
        end
        if (loadEn) mSched[loadAddr] = int'(loadData);
      end else begin
        for (int s = 0; s < 2; s++)
          if (oReq[s] && cfgDone[s]) begin mReq[s] = 0; mLoaded[s] = 1; end
        if (!oRun && oLoaded[oAct] && oBusy) begin
          mStart[oAct] = 1; mRun = 1;
          mReq[!oAct] = 1; mLoaded[!oAct] = 0;
          mIdx = mSched[(oSeg + 1) % mK];
        end
        if (oRun && slotDone[oAct]) begin
          mRun = 0; mAct = !oAct;
          if (oSeg == mK - 1) begin
            mSeg = 0; mBusy = 0; mOutStart = 1; mOutBank = oOutW; mOutW = !oOutW;
          end else mSeg = oSeg + 1;
        end
      end
      if (frameCaptured) begin
        if (!oBusy) begin mBusy = 1; mRawR = oRawW; mRawW = !oRawW; end
        else mOver = 1;
      end
    end
  end

  // ---------------- slot responders and per-cycle compare ----------------
  int cfgLat = 1, execLat = 1, framePer = 0, phaseCyc = 0;
  bit spur = 0, phaseB = 0, watchLoad = 0, bad63 = 0;
  int wrapSeen = 0, stallSeen = 0, outCount = 0, firstEntry = 0;
  int cfgCnt [2];
  int execCnt [2];

  task automatic compareAll();
    chk("R4", "cfgReq", cfgReq, mReq);
    chk("R5", "cfgIdx", cfgIdx, mIdx);
    chk(phaseB ? "R11" : "R5", "startSlot", startSlot, mStart);
    chk("R6", "slotSel", slotSel, mAct);
    chk("R7", "srcRaw", srcRaw, mSeg == 0);
    chk("R7", "dstOut", dstOut, mSeg == mK - 1);
    chk("R7", "tmpWrSel", tmpWrSel, mSeg % 2);
    chk("R7", "tmpRdSel", tmpRdSel, (mSeg % 2) == 0);
    chk("R8", "outStart", outStart, mOutStart);
    chk("R8", "outBank", outBank, mOutBank);
    chk("R8", "outWrSel", outWrSel, mOutW);
    chk("R9", "rawWrSel", rawWrSel, mRawW);
    chk("R9", "rawRdSel", rawRdSel, mRawR);
    chk("R10", "overrun", overrun, mOver);
  endtask

  task automatic tick();
    @(negedge clk);
    if (rstN) compareAll();
    if (!mIdle && mBusy && !mRun && !mLoaded[mAct]) stallSeen++;
    if (outStart) outCount++;
    if (watchLoad && cfgReq != 0 && cfgIdx == 6'd63) bad63 = 1;
    if (watchLoad && cfgReq != 0 && int'(cfgIdx) == firstEntry) wrapSeen++;
    for (int s = 0; s < 2; s++) begin
      cfgDone[s] = 1'b0;
      if (cfgReq[s]) begin
        cfgCnt[s]++;
        if (cfgCnt[s] >= cfgLat) begin cfgDone[s] = 1'b1; cfgCnt[s] = 0; end
      end else cfgCnt[s] = 0;
      slotDone[s] = 1'b0;
      if (startSlot[s]) execCnt[s] = execLat;
      else if (execCnt[s] > 0) begin
        execCnt[s]--;
        if (execCnt[s] == 0) slotDone[s] = 1'b1;
      end
    end
    if (spur && (phaseCyc % 7 == 3)) slotDone[!slotSel] = 1'b1;
    phaseCyc++;
    frameCaptured = (framePer > 0) && (phaseCyc % framePer == framePer - 1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; runEn = 0; loadEn = 0; frameCaptured = 0; cfgDone = 0; slotDone = 0;
    framePer = 0; spur = 0; phaseCyc = 0; watchLoad = 0;
    cfgCnt[0] = 0; cfgCnt[1] = 0; execCnt[0] = 0; execCnt[1] = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    // R1: reset state, sampled before any edge after release
    chk("R1", "cfgReq", cfgReq, 0);
    chk("R1", "startSlot", startSlot, 0);
    chk("R1", "outStart", outStart, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "slotSel", slotSel, 0);
    chk("R1", "rawWrSel", rawWrSel, 0);
    chk("R1", "rawRdSel", rawRdSel, 0);
    chk("R1", "outWrSel", outWrSel, 0);
  endtask

  task automatic startPhase(input int k, input int cl, input int el, input int per,
                            input bit sp, input int e0, input int e1, input int e2, input int e3);
    int ent [4];
    ent[0] = e0; ent[1] = e1; ent[2] = e2; ent[3] = e3;
    doReset();
    cfgLat = cl; execLat = el; spur = sp; firstEntry = e0;
    for (int i = 0; i < 4; i++) begin
      loadEn = 1; loadAddr = 3'(i); loadData = 6'(ent[i]);
      tick();
    end
    loadEn = 0;
    segCount = 4'(k); runEn = 1;
    tick();
    runEn = 0;
    framePer = per;
  endtask

  initial begin
    cfgCnt[0] = 0; cfgCnt[1] = 0; execCnt[0] = 0; execCnt[1] = 0;

    // R3: a zero segment count does not leave idle
    doReset();
    segCount = 0; runEn = 1;
    tick();
    runEn = 0;
    repeat (3) tick();
    chk("R3", "cfgReq after zero count", cfgReq, 0);

    // Phase A: three segments, fast slots, spurious done on idle slot, late load
    startPhase(3, 2, 4, 40, 1, 5, 17, 42, 0);
    chk("R3", "first request index", cfgIdx, 5);
    chk("R3", "first request slot", cfgReq, 1);
    repeat (60) tick();
    loadEn = 1; loadAddr = 0; loadData = 6'd63;
    tick();
    loadEn = 0; watchLoad = 1; wrapSeen = 0; outCount = 0;
    repeat (240) tick();
    chk("R2", "ignored load reached cfgIdx", bad63, 0);
    chk("R2", "entry 0 requested after late load", wrapSeen > 0, 1);
    chk("R8", "output starts seen", outCount >= 2, 1);
    chk("R10", "no overrun at slow frame rate", overrun, 0);
    watchLoad = 0;

    // Phase B: reconfiguration slower than execution
    startPhase(4, 8, 3, 70, 0, 1, 2, 3, 4);
    phaseB = 1; stallSeen = 0;
    repeat (300) tick();
    phaseB = 0;
    chk("R11", "stall cycles seen", stallSeen > 0, 1);

    // Phase C: single-segment schedule, slots alternate on the same entry
    startPhase(1, 1, 2, 15, 1, 9, 0, 0, 0);
    repeat (200) tick();

    // Phase D: count above limit is clamped, frames arrive too fast
    startPhase(12, 3, 6, 12, 0, 33, 34, 35, 36);
    repeat (300) tick();
    chk("R10", "overrun set by fast frames", overrun, 1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule